// File: doc/BRIEF.md
# Multi-Count Shift and Rotate Unit

This block shifts or rotates an 8-bit or 16-bit operand by a count of one or by a count of 0 to 31. It supports logical left and right shifts, an arithmetic right shift, and four rotates. Two of the rotates pass through the carry flag as if it were an extra bit. The block returns the result together with new carry, overflow, zero, sign and parity flags, plus an auxiliary-carry flag that is always zero. It sits beside an integer datapath that keeps the architectural flags. That datapath hands the unit the current flags so the unit can return them unchanged where the operation must not alter them.

The unit is iterative. It performs one single-bit step per clock, so a count of N takes N step cycles after the operand is accepted. Operands enter on a valid/ready handshake. `in_ready` is high only while the unit is idle, and a transfer happens on a rising edge where `in_valid` and `in_ready` are both high. Results leave on a second valid/ready handshake. Once `out_valid` rises, every output stays frozen until a rising edge with `out_ready` high. After that edge the unit is idle and ready again. The producer must hold its inputs steady until the transfer edge. The consumer may hold `out_ready` low for as long as it likes.

The carry and overflow flags follow a step rule: in a multi-step operation, only the final single-bit step decides them.

Top module: `shift_rotate_unit`

## Requirements
- R1: `in_ready` is high only when no operation is in flight. `out_valid` and `in_ready` are never high together. While `out_valid` is high and `out_ready` is low, every result output holds its value. One cycle after the output transfer, `out_valid` is low and `in_ready` is high.
- R2: Op code 0 (shift left) and op code 6 (arithmetic left) behave identically. Each step moves the top bit into CF and fills bit 0 with 0. Example: byte 8Ah by 3 gives 50h with CF=0. Example: word FFFFh by 3 gives FFF8h with CF=1.
- R3: Op code 1 (logical right) fills the top bit with 0, and each step moves bit 0 into CF. Example: byte 8Ah by 2 gives 22h with CF=1.
- R4: Op code 7 (arithmetic right) keeps the top bit in place on every step, and each step moves bit 0 into CF. Example: byte F1h by 1 gives F8h with CF=1.
- R5: Op code 2 (rotate left) copies the leaving top bit into bit 0 and into CF. Op code 3 (rotate right) copies the leaving bit 0 into the top bit and into CF.
- R6: Op code 4 (rotate left through carry) moves the old CF into bit 0 and the top bit into CF. Op code 5 (rotate right through carry) moves the old CF into the top bit and bit 0 into CF. Example: byte 8Ah by 3 with CF=1 gives B1h with CF=0.
- R7: For shifts with a count of 1 or more, OF is 1 exactly when the final single step changed the top bit. Example: byte 80h by 2 gives CF=0 and OF=0. Example: byte 40h by 1 gives OF=1.
- R8: For rotates, OF is the top-bit change of the single step when the count is 1, and OF is 0 when the count is above 1.
- R9: After a shift with a count of 1 or more, ZF, SF and PF come from the result. ZF means the result is all zero. SF is the top bit. PF is 1 when the low 8 bits hold an even number of ones. Rotates return the input ZF, SF and PF unchanged.
- R10: A count of 0 returns the operand and all input flags (CF, OF, ZF, SF, PF) unchanged.
- R11: With `in_use_cnt` low the count is 1 whatever `in_count` holds. With `in_use_cnt` high the count is `in_count` (0 to 31). Counts larger than the operand width keep stepping, one step per count.
- R12: With `in_wide` low, only bits 7:0 take part, bit 7 is the top bit, and `out_data[15:8]` reads 0. `out_af` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and command valid |
| in_ready | output | 1 | Unit idle and able to accept |
| in_data | input | 16 | Operand |
| in_op | input | 3 | Operation code (see R2 to R6) |
| in_wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit |
| in_use_cnt | input | 1 | 1 = use in_count, 0 = count of one |
| in_count | input | 5 | Step count when in_use_cnt is high |
| in_cf | input | 1 | Current carry flag |
| in_of | input | 1 | Current overflow flag |
| in_zf | input | 1 | Current zero flag |
| in_sf | input | 1 | Current sign flag |
| in_pf | input | 1 | Current parity flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Result |
| out_cf | output | 1 | New carry flag |
| out_of | output | 1 | New overflow flag |
| out_zf | output | 1 | New zero flag |
| out_sf | output | 1 | New sign flag |
| out_pf | output | 1 | New parity flag |
| out_af | output | 1 | Auxiliary carry, always 0 |

## Verification
The byte patterns 8Ah, F1h, 80h and 40h are run through each operation. These patterns separate zero fill from sign fill, show whether carry enters a rotate, and show whether OF follows the last step rather than any earlier one. A word-wide all-ones pattern and a byte operand with a non-zero upper byte separate the two operand widths. Counts of 0, 1, 2 to 4 and 31 separate the pass-through path, the single-step overflow rule, the multi-step rules and over-width counts. Held-off `out_ready` and a junk `in_count` under the single-count select check that the output stays frozen and that the count select works.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_ROL = 3'd2,
    OP_ROR = 3'd3,
    OP_RCL = 3'd4,
    OP_RCR = 3'd5,
    OP_SAL = 3'd6,
    OP_SAR = 3'd7
  } shr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } shr_state_e;

  function automatic logic op_is_rotate(shr_op_e op);
    return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
  endfunction
endpackage

// File: rtl/shr_step.sv
module shr_step
  import shr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0] v_i,
  input  logic              c_i,
  input  shr_op_e           op_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] v_o,
  output logic              c_o,
  output logic              sc_o
);
  localparam logic [DATA_W-1:0] WIDE_MASK   = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'({NARROW_W{1'b1}});
  localparam logic [DATA_W-1:0] WIDE_TOP    = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] NARROW_TOP  = DATA_W'(1) << (NARROW_W - 1);

  logic [DATA_W-1:0] mask, top, raw, v_in;
  logic              msb_old, msb_new, lsb_old;

  always_comb begin
    mask    = wide_i ? WIDE_MASK : NARROW_MASK;
    top     = wide_i ? WIDE_TOP : NARROW_TOP;
    v_in    = v_i & mask;
    msb_old = |(v_in & top);
    lsb_old = v_in[0];
    raw     = '0;
    c_o     = 1'b0;
    unique case (op_i)
      OP_SHL, OP_SAL: begin raw = v_in << 1;                         c_o = msb_old; end
      OP_SHR:         begin raw = v_in >> 1;                         c_o = lsb_old; end
      OP_SAR:         begin raw = (v_in >> 1) | (msb_old ? top : '0); c_o = lsb_old; end
      OP_ROL:         begin raw = (v_in << 1) | DATA_W'(msb_old);    c_o = msb_old; end
      OP_ROR:         begin raw = (v_in >> 1) | (lsb_old ? top : '0); c_o = lsb_old; end
      OP_RCL:         begin raw = (v_in << 1) | DATA_W'(c_i);        c_o = msb_old; end
      OP_RCR:         begin raw = (v_in >> 1) | (c_i ? top : '0);     c_o = lsb_old; end
      default:        begin raw = v_in;                              c_o = c_i;     end
    endcase
    v_o     = raw & mask;
    msb_new = |(v_o & top);
    sc_o    = msb_old ^ msb_new;
  end
endmodule

// File: rtl/shr_count.sv
module shr_count #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             last_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/shr_flags.sv
module shr_flags #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int PAR_W    = 8
) (
  input  logic [DATA_W-1:0] r_i,
  input  logic              wide_i,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o
);
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'({NARROW_W{1'b1}});

  logic [DATA_W-1:0] rm;

  always_comb begin
    rm   = wide_i ? r_i : (r_i & NARROW_MASK);
    zf_o = (rm == '0);
    sf_o = wide_i ? rm[DATA_W-1] : rm[NARROW_W-1];
    pf_o = ~^rm[PAR_W-1:0];
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [2:0]        in_op,
  input  logic              in_wide,
  input  logic              in_use_cnt,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              in_cf,
  input  logic              in_of,
  input  logic              in_zf,
  input  logic              in_sf,
  input  logic              in_pf,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_cf,
  output logic              out_of,
  output logic              out_zf,
  output logic              out_sf,
  output logic              out_pf,
  output logic              out_af
);
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'({NARROW_W{1'b1}});

  shr_state_e        state_q;
  shr_op_e           op_q;
  logic [DATA_W-1:0] val_q;
  logic              cf_q, of_q, wide_q, multi_q, zero_q;
  logic              zf_in_q, sf_in_q, pf_in_q, of_in_q;

  logic              accept;
  logic [CNT_W-1:0]  cnt_eff;
  logic              cnt_last, cnt_zero;
  logic [DATA_W-1:0] step_v;
  logic              step_c, step_sc;
  logic              fl_zf, fl_sf, fl_pf, rot;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign accept    = in_valid && in_ready;
  assign cnt_eff   = in_use_cnt ? in_count : CNT_W'(1);

  shr_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .val_i  (cnt_eff),
    .dec_i  (state_q == ST_RUN),
    .last_o (cnt_last),
    .zero_o (cnt_zero)
  );

  shr_step #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_step (
    .v_i    (val_q),
    .c_i    (cf_q),
    .op_i   (op_q),
    .wide_i (wide_q),
    .v_o    (step_v),
    .c_o    (step_c),
    .sc_o   (step_sc)
  );

  shr_flags #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .PAR_W(NARROW_W)) u_flags (
    .r_i    (val_q),
    .wide_i (wide_q),
    .zf_o   (fl_zf),
    .sf_o   (fl_sf),
    .pf_o   (fl_pf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_SHL;
      val_q   <= '0;
      cf_q    <= 1'b0;
      of_q    <= 1'b0;
      wide_q  <= 1'b0;
      multi_q <= 1'b0;
      zero_q  <= 1'b0;
      zf_in_q <= 1'b0;
      sf_in_q <= 1'b0;
      pf_in_q <= 1'b0;
      of_in_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= shr_op_e'(in_op);
          val_q   <= in_wide ? in_data : (in_data & NARROW_MASK);
          cf_q    <= in_cf;
          of_q    <= in_of;
          wide_q  <= in_wide;
          multi_q <= (cnt_eff > CNT_W'(1));
          zero_q  <= (cnt_eff == '0);
          zf_in_q <= in_zf;
          sf_in_q <= in_sf;
          pf_in_q <= in_pf;
          of_in_q <= in_of;
          state_q <= (cnt_eff == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          val_q <= step_v;
          cf_q  <= step_c;
          of_q  <= step_sc;
          if (cnt_last || cnt_zero) state_q <= ST_DONE;
        end
        ST_DONE: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rot      = op_is_rotate(op_q);
    out_data = val_q;
    out_cf   = cf_q;
    out_af   = 1'b0;
    if (zero_q) begin
      out_of = of_in_q;
      out_zf = zf_in_q;
      out_sf = sf_in_q;
      out_pf = pf_in_q;
    end else if (rot) begin
      out_of = multi_q ? 1'b0 : of_q;
      out_zf = zf_in_q;
      out_sf = sf_in_q;
      out_pf = pf_in_q;
    end else begin
      out_of = of_q;
      out_zf = fl_zf;
      out_sf = fl_sf;
      out_pf = fl_pf;
    end
  end

  // R1: output frozen under back-pressure
  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_cf)
                                   && $stable(out_of) && $stable(out_zf)));
  // R1: handshakes exclusive
  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R2: a left shift step always clears bit 0
  p_shl_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && (op_q == OP_SHL || op_q == OP_SAL)) |-> (step_v[0] == 1'b0));
  // R5: plain rotate keeps the number of ones
  p_rot_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && (op_q == OP_ROL || op_q == OP_ROR))
      |-> ($countones(step_v) == $countones(val_q)));
  // R10: zero count returns the operand on the next cycle
  p_zero_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cnt_eff == '0 && in_wide) |=> (out_valid && out_data == $past(in_data)));
  // R12: byte mode clears the upper byte
  p_byte_upper_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> (out_data[DATA_W-1:NARROW_W] == '0));
endmodule

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_data = '0;
  logic [2:0]  in_op = '0;
  logic        in_wide = 1'b0, in_use_cnt = 1'b0;
  logic [4:0]  in_count = '0;
  logic        in_cf = 1'b0, in_of = 1'b0, in_zf = 1'b0, in_sf = 1'b0, in_pf = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_cf, out_of, out_zf, out_sf, out_pf, out_af;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rotate_unit u_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_op(in_op),
    .in_wide(in_wide), .in_use_cnt(in_use_cnt), .in_count(in_count),
    .in_cf(in_cf), .in_of(in_of), .in_zf(in_zf), .in_sf(in_sf), .in_pf(in_pf),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_cf(out_cf), .out_of(out_of), .out_zf(out_zf), .out_sf(out_sf),
    .out_pf(out_pf), .out_af(out_af)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // issue one operation, wait for the result, hold it for 'stall' cycles, then check
  task automatic run_op(input string req, input logic [2:0] op, input logic wide,
                        input logic use_cnt, input logic [4:0] cnt, input logic [15:0] d,
                        input logic [4:0] fin, input int stall,
                        input logic [15:0] e_d, input logic [4:0] e_fl);
    // fin / e_fl packing: {cf, of, zf, sf, pf}
    int waitc;
    logic [15:0] d0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = d; in_op = op; in_wide = wide; in_use_cnt = use_cnt; in_count = cnt;
    {in_cf, in_of, in_zf, in_sf, in_pf} = fin;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    waitc = 0;
    while (!out_valid && waitc < 100) begin @(negedge clk); waitc++; end
    check(req, "result valid", {15'd0, out_valid}, 16'd1);
    check("R1", "ready low while result pending", {15'd0, in_ready}, 16'd0);
    d0 = out_data;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check("R1", "held data", out_data, d0);
      check("R1", "held valid", {15'd0, out_valid}, 16'd1);
    end
    check(req, "data", out_data, e_d);
    check(req, "flags cf,of,zf,sf,pf", {11'd0, out_cf, out_of, out_zf, out_sf, out_pf}, {11'd0, e_fl});
    check("R12", "af", {15'd0, out_af}, 16'd0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R1", "valid drops after transfer", {15'd0, out_valid}, 16'd0);
    check("R1", "ready returns after transfer", {15'd0, in_ready}, 16'd1);
  endtask

  task automatic t_reset;
    check("R1", "reset in_ready", {15'd0, in_ready}, 16'd1);
    check("R1", "reset out_valid", {15'd0, out_valid}, 16'd0);
  endtask
  task automatic t_shl_byte;  run_op("R2", 3'd0, 0, 1, 5'd3, 16'h008A, 5'b00000, 3, 16'h0050, 5'b00001); endtask
  task automatic t_sal_word;  run_op("R2", 3'd6, 1, 1, 5'd3, 16'hFFFF, 5'b00000, 0, 16'hFFF8, 5'b10010); endtask
  task automatic t_shr;       run_op("R3", 3'd1, 0, 1, 5'd2, 16'h008A, 5'b00000, 0, 16'h0022, 5'b10001); endtask
  task automatic t_sar_r11;   run_op("R4", 3'd7, 0, 0, 5'd7, 16'h00F1, 5'b00000, 0, 16'h00F8, 5'b10010); endtask
  task automatic t_rol;       run_op("R5", 3'd2, 0, 1, 5'd1, 16'h0081, 5'b00010, 0, 16'h0003, 5'b11010); endtask
  task automatic t_ror;       run_op("R5", 3'd3, 0, 1, 5'd4, 16'h0001, 5'b01101, 0, 16'h0010, 5'b00101); endtask
  task automatic t_rcr;       run_op("R6", 3'd5, 0, 1, 5'd3, 16'h008A, 5'b10101, 2, 16'h00B1, 5'b00101); endtask
  task automatic t_rcl_r8;    run_op("R8", 3'd4, 1, 1, 5'd1, 16'h8000, 5'b00000, 0, 16'h0000, 5'b11000); endtask
  task automatic t_of_multi;  run_op("R7", 3'd0, 0, 1, 5'd2, 16'h0080, 5'b00000, 0, 16'h0000, 5'b00101); endtask
  task automatic t_of_single; run_op("R7", 3'd0, 0, 1, 5'd1, 16'h0040, 5'b00000, 0, 16'h0080, 5'b01010); endtask
  task automatic t_flags_r9;  run_op("R9", 3'd1, 1, 1, 5'd4, 16'h0F00, 5'b00111, 0, 16'h00F0, 5'b00001); endtask
  task automatic t_zero_cnt;  run_op("R10", 3'd1, 0, 1, 5'd0, 16'h005A, 5'b11100, 1, 16'h005A, 5'b11100); endtask
  task automatic t_byte_r12;  run_op("R12", 3'd0, 0, 0, 5'd0, 16'h3C81, 5'b00000, 0, 16'h0002, 5'b11000); endtask
  task automatic t_long_r11;  run_op("R11", 3'd0, 0, 1, 5'd31, 16'h00FF, 5'b00000, 0, 16'h0000, 5'b00101); endtask

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG && !finished; i++) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shl_byte();
    t_sal_word();
    t_shr();
    t_sar_r11();
    t_rol();
    t_ror();
    t_rcr();
    t_rcl_r8();
    t_of_multi();
    t_of_single();
    t_flags_r9();
    t_zero_cnt();
    t_byte_r12();
    t_long_r11();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule